// File: doc/BRIEF.md
# Ring Buffer Pointer and Residual Tracker

This block keeps the three bit addresses that steer a circular audio buffer held in external memory. The first is a write pointer that the encoder moves on. The second is a read pointer that the decoder moves on. The third is a validated write pointer, which marks the end of the data that software has confirmed as good. All three wrap modulo a power-of-two memory size.

Confirmation works in two steps. On every falling edge of the subcode block clock, the block takes a snapshot of the write pointer. Later, a validate command from software promotes that snapshot to the validated pointer. The validated pointer therefore always lags the write pointer.

From the validated pointer and the read pointer the block derives three results:
- the residual amount of valid data, reported as the upper bits of the modulo difference of the two;
- an empty flag;
- two overflow indications: a level that stays up while the writer has lapped the reader, and a read-once event that a status read clears.

Top module: `ring_ptr_tracker`

## Requirements
- R1: After reset, all three pointers read 0, the residual reads 0, the empty flag is 1, and both overflow flags are 0.
- R2: Each cycle with the write-advance strobe high adds 1 (modulo 2^PTR_W) to the write pointer. The write-clear command forces it to 0 and wins over an advance in the same cycle.
- R3: The read-advance strobe adds 1 (modulo 2^PTR_W) to the read pointer only while the empty flag is 0. While empty, the strobe leaves the read pointer unchanged. The read-clear command forces the pointer to 0 and wins over an advance.
- R4: On a cycle where the block clock input is 0 and was 1 in the previous cycle, the block stores the write pointer value held before that cycle's advance. A rising edge, or a steady level, stores nothing.
- R5: The validate command copies the stored snapshot into the validated pointer. If a block-clock falling edge arrives in the same cycle, the pointer receives the snapshot taken before that edge. Without the validate command, the validated pointer holds its value.
- R6: The residual output equals bits [PTR_W-1:RES_LSB] of (validated pointer − read pointer) taken modulo 2^PTR_W.
- R7: The empty flag is 1 exactly when the validated pointer equals the read pointer.
- R8: The overflow-state flag sets on a write advance that makes the write pointer equal to the read pointer as that pointer stands after the same cycle. The flag never sets because of a clear or a reset. It clears in the first cycle after a read advance that actually moves the read pointer.
- R9: The overflow-event flag sets under the same condition as R8. A status-read pulse clears it even while the overflow state persists. A set in the same cycle wins over the status read.
- R10: Either clear command drops both overflow flags, and it wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_adv_i | input | 1 | Write pointer advance strobe |
| rd_adv_i | input | 1 | Read pointer advance strobe |
| wr_clr_i | input | 1 | Write pointer clear command |
| rd_clr_i | input | 1 | Read pointer clear command |
| blk_clk_i | input | 1 | Subcode block clock, sampled synchronously |
| validate_i | input | 1 | Promote the stored snapshot to the validated pointer |
| stat_rd_i | input | 1 | Status-read pulse; clears the overflow event |
| wr_ptr_o | output | 22 | Write pointer |
| rd_ptr_o | output | 22 | Read pointer |
| vwr_ptr_o | output | 22 | Validated write pointer |
| residual_o | output | 16 | Valid data residual, bits [21:6] of the difference |
| empty_o | output | 1 | Validated pointer equals read pointer |
| ovf_state_o | output | 1 | Writer has lapped the reader |
| ovf_event_o | output | 1 | Read-once overflow event |

## Verification
The pointers, the validated pointer and both overflow flags are registered, so each one shows the effect of a stimulus one clock after the edge that samples it. The exception is the block-clock snapshot: it becomes visible only through a later validate command, one clock after that command. The residual and the empty flag are combinational from registers, so they follow in the same cycle as the pointers they depend on. The bench drives every input on a falling clock edge and advances its reference model at the rising edge. It compares all outputs at the next falling edge, which is exactly one register stage after the stimulus.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    typedef struct packed {
        logic lapped;   // overflow state level
        logic latched;  // read-once overflow event
    } ovf_flags_t;

    localparam ovf_flags_t FLAGS_CLEAR = '{lapped: 1'b0, latched: 1'b0};

endpackage

// File: rtl/rbp_fall_detect.sv
module rbp_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/rbp_ring_ptr.sv
module rbp_ring_ptr #(
    parameter int PTR_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] next_o
);
    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i)      ptr_d = '0;
        else if (adv_i) ptr_d = ptr_q + PTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o  = ptr_q;
    assign next_o = ptr_d;
endmodule

// File: rtl/rbp_residual.sv
module rbp_residual #(
    parameter int PTR_W   = 22,
    parameter int RES_LSB = 6,
    localparam int RES_W  = PTR_W - RES_LSB
) (
    input  logic [PTR_W-1:0] vwr_i,
    input  logic [PTR_W-1:0] rd_i,
    output logic [RES_W-1:0] residual_o,
    output logic             empty_o
);
    logic lo_borrow;

    always_comb begin
        // Upper-field subtraction with the borrow out of the dropped low bits
        lo_borrow  = vwr_i[RES_LSB-1:0] < rd_i[RES_LSB-1:0];
        residual_o = vwr_i[PTR_W-1:RES_LSB] - rd_i[PTR_W-1:RES_LSB]
                     - RES_W'(lo_borrow);
        empty_o    = (vwr_i == rd_i);
    end
endmodule

// File: rtl/ring_ptr_tracker.sv
module ring_ptr_tracker #(
    parameter int PTR_W   = 22,
    parameter int RES_LSB = 6,
    localparam int RES_W  = PTR_W - RES_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_adv_i,
    input  logic             rd_adv_i,
    input  logic             wr_clr_i,
    input  logic             rd_clr_i,
    input  logic             blk_clk_i,
    input  logic             validate_i,
    input  logic             stat_rd_i,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [PTR_W-1:0] vwr_ptr_o,
    output logic [RES_W-1:0] residual_o,
    output logic             empty_o,
    output logic             ovf_state_o,
    output logic             ovf_event_o
);
    import rbp_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0] held;   // snapshot taken at block clock fall
        logic [PTR_W-1:0] vwr;    // validated write pointer
        ovf_flags_t       flags;
    } trk_state_t;

    trk_state_t       st_d, st_q;
    logic             blk_fall;
    logic             rd_step;
    logic             lap_hit;
    logic             any_clr;
    logic [PTR_W-1:0] wr_ptr, wr_next;
    logic [PTR_W-1:0] rd_ptr, rd_next;
    logic             empty;

    rbp_fall_detect u_blk_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (blk_clk_i),
        .fall_o  (blk_fall)
    );

    rbp_ring_ptr #(.PTR_W(PTR_W)) u_wr_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (wr_clr_i),
        .adv_i  (wr_adv_i),
        .ptr_o  (wr_ptr),
        .next_o (wr_next)
    );

    // The reader may not step past the validated pointer
    assign rd_step = rd_adv_i & ~empty & ~rd_clr_i;

    rbp_ring_ptr #(.PTR_W(PTR_W)) u_rd_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (rd_clr_i),
        .adv_i  (rd_step),
        .ptr_o  (rd_ptr),
        .next_o (rd_next)
    );

    rbp_residual #(.PTR_W(PTR_W), .RES_LSB(RES_LSB)) u_residual (
        .vwr_i      (st_q.vwr),
        .rd_i       (rd_ptr),
        .residual_o (residual_o),
        .empty_o    (empty)
    );

    always_comb begin
        st_d    = st_q;
        any_clr = wr_clr_i | rd_clr_i;
        lap_hit = wr_adv_i & ~wr_clr_i & (wr_next == rd_next);

        if (blk_fall)   st_d.held = wr_ptr;
        // Promotion uses the registered snapshot, i.e. the pre-edge value
        if (validate_i) st_d.vwr  = st_q.held;

        if (any_clr) begin
            st_d.flags = FLAGS_CLEAR;
        end else if (lap_hit) begin
            st_d.flags.lapped  = 1'b1;
            st_d.flags.latched = 1'b1;
        end else begin
            if (rd_step)   st_d.flags.lapped  = 1'b0;
            if (stat_rd_i) st_d.flags.latched = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.held  <= '0;
            st_q.vwr   <= '0;
            st_q.flags <= FLAGS_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr_o    = wr_ptr;
    assign rd_ptr_o    = rd_ptr;
    assign vwr_ptr_o   = st_q.vwr;
    assign empty_o     = empty;
    assign ovf_state_o = st_q.flags.lapped;
    assign ovf_event_o = st_q.flags.latched;
endmodule

// File: rtl/ring_ptr_tracker_chk.sv
module ring_ptr_tracker_chk #(
    parameter int PTR_W   = 22,
    parameter int RES_LSB = 6,
    localparam int RES_W  = PTR_W - RES_LSB
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_adv_i,
    input logic             wr_clr_i,
    input logic             rd_clr_i,
    input logic             validate_i,
    input logic             stat_rd_i,
    input logic [PTR_W-1:0] wr_ptr_o,
    input logic [PTR_W-1:0] rd_ptr_o,
    input logic [PTR_W-1:0] vwr_ptr_o,
    input logic [RES_W-1:0] residual_o,
    input logic             empty_o,
    input logic             ovf_state_o,
    input logic             ovf_event_o
);
    assert_wr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr_i |=> (wr_ptr_o == '0));

    assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_adv_i && !wr_clr_i) |=> ((wr_ptr_o - $past(wr_ptr_o)) == PTR_W'(1)));

    assert_rd_hold_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !rd_clr_i) |=> $stable(rd_ptr_o));

    assert_vwr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !validate_i |=> $stable(vwr_ptr_o));

    assert_residual_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (residual_o != '0) |-> !empty_o);

    assert_ovf_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_state_o) |-> $past(wr_adv_i && !wr_clr_i && !rd_clr_i));

    assert_event_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_event_o) |-> $past(stat_rd_i || wr_clr_i || rd_clr_i));

    assert_clear_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr_i || rd_clr_i) |=> (!ovf_state_o && !ovf_event_o));
endmodule

bind ring_ptr_tracker ring_ptr_tracker_chk #(.PTR_W(PTR_W), .RES_LSB(RES_LSB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_adv_i    (wr_adv_i),
    .wr_clr_i    (wr_clr_i),
    .rd_clr_i    (rd_clr_i),
    .validate_i  (validate_i),
    .stat_rd_i   (stat_rd_i),
    .wr_ptr_o    (wr_ptr_o),
    .rd_ptr_o    (rd_ptr_o),
    .vwr_ptr_o   (vwr_ptr_o),
    .residual_o  (residual_o),
    .empty_o     (empty_o),
    .ovf_state_o (ovf_state_o),
    .ovf_event_o (ovf_event_o)
);

// File: tb/ring_ptr_tracker_test.sv
module ring_ptr_tracker_test;
    localparam int PW  = 8;
    localparam int LSB = 2;
    localparam int RW  = PW - LSB;
    localparam int M   = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_adv = 0, rd_adv = 0, wr_clr = 0, rd_clr = 0;
    logic blk = 0, val = 0, srd = 0;
    logic [PW-1:0] wr_ptr, rd_ptr, vwr_ptr;
    logic [RW-1:0] residual;
    logic empty, ovs, ove;

    int vectors = 0;
    int fails = 0;

    // reference model state
    int m_wa = 0, m_ra = 0, m_vwa = 0, m_held = 0, m_prev = 0, m_ovs = 0, m_ove = 0;
    int lfsr = 32'h1ACE;

    always #4 clk = ~clk;

    ring_ptr_tracker #(.PTR_W(PW), .RES_LSB(LSB)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_adv_i(wr_adv), .rd_adv_i(rd_adv),
        .wr_clr_i(wr_clr), .rd_clr_i(rd_clr),
        .blk_clk_i(blk), .validate_i(val), .stat_rd_i(srd),
        .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .vwr_ptr_o(vwr_ptr),
        .residual_o(residual), .empty_o(empty),
        .ovf_state_o(ovs), .ovf_event_o(ove)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 wr_ptr", int'(wr_ptr), m_wa);
        chk("R3 rd_ptr", int'(rd_ptr), m_ra);
        chk("R5 vwr_ptr", int'(vwr_ptr), m_vwa);
        chk("R6 residual", int'(residual), ((m_vwa - m_ra + M) % M) >> LSB);
        chk("R7 empty", int'(empty), (m_vwa == m_ra) ? 1 : 0);
        chk("R8 ovf_state", int'(ovs), m_ovs);
        chk("R9 ovf_event", int'(ove), m_ove);
    endtask

    // Called at a falling edge; applies inputs for one cycle and checks after it
    task automatic step(input logic wa, input logic ra, input logic wc, input logic rc,
                        input logic bk, input logic vl, input logic sr);
        int n_wa, n_ra, n_vwa, n_held, n_ovs, n_ove;
        bit moved, hit, fall;
        wr_adv = wa; rd_adv = ra; wr_clr = wc; rd_clr = rc;
        blk = bk; val = vl; srd = sr;
        fall   = (m_prev == 1) && !bk;
        n_held = fall ? m_wa : m_held;
        n_vwa  = vl ? m_held : m_vwa;
        moved  = !rc && ra && (m_vwa != m_ra);
        n_ra   = rc ? 0 : (moved ? (m_ra + 1) % M : m_ra);
        n_wa   = wc ? 0 : (wa ? (m_wa + 1) % M : m_wa);
        hit    = !wc && wa && (n_wa == n_ra);
        if (wc || rc) begin
            n_ovs = 0; n_ove = 0;
        end else if (hit) begin
            n_ovs = 1; n_ove = 1;
        end else begin
            n_ovs = moved ? 0 : m_ovs;
            n_ove = sr ? 0 : m_ove;
        end
        @(posedge clk);
        m_wa = n_wa; m_ra = n_ra; m_vwa = n_vwa; m_held = n_held;
        m_ovs = n_ovs; m_ove = n_ove; m_prev = bk ? 1 : 0;
        @(negedge clk);
        compare_all();
    endtask

    task automatic writes(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 wr_ptr", int'(wr_ptr), 0);
        chk("R1 rd_ptr", int'(rd_ptr), 0);
        chk("R1 vwr_ptr", int'(vwr_ptr), 0);
        chk("R1 empty", int'(empty), 1);
        chk("R1 ovf", int'({ovs, ove}), 0);
        compare_all();

        // R2: ten writes
        writes(10);
        chk("R2 ten writes", int'(wr_ptr), 10);
        // R4: rise then fall captures 10; R5: validate promotes it
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R4 snapshot via validate", int'(vwr_ptr), 10);
        chk("R6 residual 10>>2", int'(residual), 2);
        chk("R7 not empty", int'(empty), 0);

        // R5: validate on the same cycle as a fall gets the pre-edge snapshot
        writes(6);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R5 same-cycle validate", int'(vwr_ptr), 10);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R5 later validate", int'(vwr_ptr), 16);

        // R3: reads stop at the validated pointer
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 0, 0, 0);
        chk("R3 read stops at vwr", int'(rd_ptr), 16);
        chk("R7 empty after drain", int'(empty), 1);

        // R10: a lapping write with a clear sets nothing
        writes(255);
        step(1, 0, 1, 0, 0, 0, 0);
        chk("R10 clear beats lap", int'({ovs, ove}), 0);
        chk("R2 clear beats advance", int'(wr_ptr), 0);

        // R8/R9: writer laps the reader (0 -> 16)
        writes(16);
        chk("R8 lap sets state", int'(ovs), 1);
        chk("R9 lap sets event", int'(ove), 1);
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R9 status read clears event", int'(ove), 0);
        chk("R9 state persists", int'(ovs), 1);
        step(0, 1, 0, 0, 0, 0, 0);
        chk("R8 empty read keeps state", int'(ovs), 1);
        writes(4);
        step(0, 0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        step(0, 1, 0, 0, 0, 0, 0);
        chk("R8 read advance clears state", int'(ovs), 0);
        chk("R6 residual after read", int'(residual), (20 - 17) >> LSB);

        // R9: lap together with status read keeps the event set
        writes(252);
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R9 set beats status read", int'(ove), 1);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R10 read clear drops flags", int'({ovs, ove}), 0);
        chk("R3 read clear", int'(rd_ptr), 0);

        // Mixed pseudo-random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            step(lfsr[0] | lfsr[5], lfsr[1] & lfsr[6],
                 (lfsr[15:10] == 6'h3F), (lfsr[15:10] == 6'h15),
                 lfsr[3] & lfsr[9], (lfsr[8:7] == 2'b11), lfsr[4] & lfsr[12]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule